// File: doc/BRIEF.md
# Mode-Aware GPIO Port Controller

This block drives one general-purpose I/O port of a configurable width (eight pins by default). Software reaches it through a small register bus. A data latch holds the values to drive. A direction register picks input or output for each pin. A single enable bit turns on pull-ups for every pin that is an input. A drive-strength bit, which can be written only once after reset, lowers the drive of every pin that is driving.

A two-bit mode input decides who owns the pins. In single-chip mode the port registers own them. In the two expanded modes and in peripheral mode, the external address/data path's value and enable pass straight through to the pads. The data and direction registers then drop out of the address map, but they keep their contents. Pin levels pass through a two-flop synchronizer before software can read them back.

Top module: `gpio_port_ctl`

## Requirements
- R1: In single-chip mode (`mode`=00), a direction bit of 1 drives the matching `pad_oe` bit high and puts the data latch bit on `pad_out`. A direction bit of 0 leaves that pin undriven, as an input.
- R2: After reset, the data latch, direction, pull-up bit, drive bit and write lock are all zero, so every pin starts as an input.
- R3: In modes 01 and 10 (expanded) and 11 (peripheral), writes to the data register (offset 0) and the direction register (offset 1) are ignored and reads of them return zero. In these modes `pad_out` follows `ext_out` and `pad_oe` follows `ext_oe`.
- R4: In single-chip mode, a read at offset 0 returns the latch value for output bits and the synchronized pin level for input bits. A pin change becomes visible after two rising clock edges.
- R5: In single-chip mode, when the pull-up bit (offset 2, bit 0) is set, `pad_pu` is high for exactly the pins whose direction bit is 0. The pull-up register is mapped in every mode.
- R6: In the expanded and peripheral modes, `pad_pu` is all zero whatever the pull-up bit holds.
- R7: When the drive bit (offset 3, bit 0) is set, `pad_rdrv` is high for exactly the pins whose `pad_oe` is high. When the drive bit is clear, `pad_rdrv` is all zero.
- R8: The first accepted write to offset 3 after reset sets the drive bit and locks it. Every later write leaves the drive bit unchanged until the next reset.
- R9: In peripheral mode, offset 3 reads zero and a write there is ignored and does not use up the one allowed write.
- R10: Reads return zero when `rd_en` is low, at the unused offsets 4 to 7, and in bits 7:1 of offsets 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 single-chip, 01/10 expanded, 11 peripheral |
| addr | input | ADDR_W (3) | Register offset |
| wdata | input | W (8) | Write data |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; read data is combinational |
| rdata | output | W (8) | Read data, zero when rd_en is low |
| pin_in | input | W (8) | Pin levels from the pads |
| ext_out | input | W (8) | Output values from the external address/data path |
| ext_oe | input | W (8) | Output enables from the external address/data path |
| pad_out | output | W (8) | Value driven to each pad |
| pad_oe | output | W (8) | Output enable for each pad |
| pad_pu | output | W (8) | Pull-up enable for each pad |
| pad_rdrv | output | W (8) | Reduced-drive enable for each pad |

## Verification
The assertions check rules that must hold on every cycle. A pull-up is never active on a driving pin, and every pull-up is off outside single-chip mode. Reduced drive reaches only driving pins. The locked drive bit never moves. In non-single-chip modes, data and direction reads return zero and data writes change nothing. In peripheral mode, a drive write does not set the lock.

Some behaviour needs a sequence of operations, so only the bench scenarios can show it: the two-edge synchronizer latency, latch contents surviving a trip through expanded mode, and the lock staying free after a peripheral-mode write, then closing on the next single-chip write. The same holds for read-back that mixes latch and pin bits under random direction patterns.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  typedef logic [1:0] mode_t;

  localparam mode_t MODE_SINGLE     = 2'b00;
  localparam mode_t MODE_EXP_NARROW = 2'b01;
  localparam mode_t MODE_EXP_WIDE   = 2'b10;
  localparam mode_t MODE_PERIPH     = 2'b11;

  localparam int OFS_DATA  = 0;
  localparam int OFS_DIR   = 1;
  localparam int OFS_PULL  = 2;
  localparam int OFS_DRIVE = 3;

  // Data and direction registers own the pins only in single-chip mode
  function automatic logic port_owned(input mode_t m);
    return m == MODE_SINGLE;
  endfunction

  // Drive-strength register drops out of the map only in peripheral mode
  function automatic logic drive_visible(input mode_t m);
    return m != MODE_PERIPH;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic              pull_q,
  output logic              drv_q,
  output logic              lock_q,
  output logic              data_wr_acc,
  output logic              dir_wr_acc,
  output logic              pull_wr_acc,
  output logic              drv_wr_acc
);
  logic sel_data, sel_dir, sel_pull, sel_drive;

  assign sel_data  = addr == ADDR_W'(OFS_DATA);
  assign sel_dir   = addr == ADDR_W'(OFS_DIR);
  assign sel_pull  = addr == ADDR_W'(OFS_PULL);
  assign sel_drive = addr == ADDR_W'(OFS_DRIVE);

  // Named write events, visible to the checker
  assign data_wr_acc = wr_en & sel_data  & port_owned(mode);
  assign dir_wr_acc  = wr_en & sel_dir   & port_owned(mode);
  assign pull_wr_acc = wr_en & sel_pull;
  assign drv_wr_acc  = wr_en & sel_drive & drive_visible(mode) & ~lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      pull_q <= 1'b0;
      drv_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (data_wr_acc) data_q <= wdata;
      if (dir_wr_acc)  dir_q  <= wdata;
      if (pull_wr_acc) pull_q <= wdata[0];
      if (drv_wr_acc) begin
        drv_q  <= wdata[0];
        lock_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
`timescale 1ns/1ps
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic         pull_q,
  input  logic         drv_q,
  input  logic [W-1:0] ext_out,
  input  logic [W-1:0] ext_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_rdrv
);
  logic ext_sel;
  assign ext_sel = ~port_owned(mode);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_out[i]  = ext_sel ? ext_out[i] : data_q[i];
    assign pad_oe[i]   = ext_sel ? ext_oe[i]  : dir_q[i];
    assign pad_pu[i]   = pull_q & ~ext_sel & ~dir_q[i];
    assign pad_rdrv[i] = drv_q & pad_oe[i];
  end
endmodule

// File: rtl/gpio_port_ctl.sv
`timescale 1ns/1ps
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      ext_out,
  input  logic [W-1:0]      ext_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  output logic [W-1:0]      pad_rdrv
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] data_q, dir_q, pin_sync;
  logic         pull_q, drv_q, lock_q;
  logic         data_wr_acc, dir_wr_acc, pull_wr_acc, drv_wr_acc;
  logic [W-1:0] rd_value;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_port_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q),
    .drv_q(drv_q), .lock_q(lock_q), .data_wr_acc(data_wr_acc),
    .dir_wr_acc(dir_wr_acc), .pull_wr_acc(pull_wr_acc), .drv_wr_acc(drv_wr_acc)
  );

  gpio_pad_drive #(.W(W)) u_pad (
    .mode(mode), .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q),
    .drv_q(drv_q), .ext_out(ext_out), .ext_oe(ext_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_rdrv(pad_rdrv)
  );

  // Output bits read the latch, input bits read the synchronized pin
  function automatic logic [W-1:0] port_view(input logic [W-1:0] dir,
                                             input logic [W-1:0] lat,
                                             input logic [W-1:0] pin);
    return (dir & lat) | (~dir & pin);
  endfunction

  function automatic logic [W-1:0] flag_word(input logic b);
    return {{(W-1){1'b0}}, b};
  endfunction

  always_comb begin
    rd_value = ZERO;
    case (addr)
      ADDR_W'(OFS_DATA):  if (port_owned(mode)) rd_value = port_view(dir_q, data_q, pin_sync);
      ADDR_W'(OFS_DIR):   if (port_owned(mode)) rd_value = dir_q;
      ADDR_W'(OFS_PULL):  rd_value = flag_word(pull_q);
      ADDR_W'(OFS_DRIVE): if (drive_visible(mode)) rd_value = flag_word(drv_q);
      default:            rd_value = ZERO;
    endcase
  end

  assign rdata = rd_en ? rd_value : ZERO;
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [W-1:0]      rdata,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_pu,
  input logic [W-1:0]      pad_rdrv,
  input logic [W-1:0]      data_q,
  input logic              drv_q,
  input logic              lock_q
);
  logic reg_hidden_addr;
  assign reg_hidden_addr = (addr == ADDR_W'(OFS_DATA)) || (addr == ADDR_W'(OFS_DIR));

  AST_PU_NOT_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);  // R5
  AST_PU_OFF_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    mode != MODE_SINGLE |-> pad_pu == '0);  // R6
  AST_RDRV_ONLY_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_rdrv & ~pad_oe) == '0);  // R7
  AST_DRV_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(drv_q) && lock_q);  // R8
  AST_HIDDEN_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode != MODE_SINGLE && reg_hidden_addr |-> rdata == '0);  // R3
  AST_HIDDEN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode != MODE_SINGLE && addr == ADDR_W'(OFS_DATA) |=> $stable(data_q));  // R3
  AST_PERIPH_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode == MODE_PERIPH && addr == ADDR_W'(OFS_DRIVE) |=> $stable(lock_q));  // R9
endmodule

bind gpio_port_ctl gpio_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .pad_rdrv(pad_rdrv), .data_q(data_q), .drv_q(drv_q), .lock_q(lock_q)
);

// File: tb/gpio_port_ctl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctl_bench;
  localparam logic [1:0] M_SC = 2'b00, M_XN = 2'b01, M_XW = 2'b10, M_PE = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = M_SC;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata, pin_in = '0, ext_out = '0, ext_oe = '0;
  logic [7:0] pad_out, pad_oe, pad_pu, pad_rdrv;

  int total = 0, bad = 0;

  // Reference state kept from the requirements
  logic [7:0] m_data, m_dir;
  logic       m_pull, m_drv, m_lock;

  always #2.5 clk = ~clk;

  gpio_port_ctl u_gpio_port_ctl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in),
    .ext_out(ext_out), .ext_oe(ext_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_rdrv(pad_rdrv)
  );

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return (mode == M_SC) ? ((m_dir & m_data) | (~m_dir & pin_in)) : 8'h00;
      3'd1: return (mode == M_SC) ? m_dir : 8'h00;
      3'd2: return {7'b0, m_pull};
      3'd3: return (mode != M_PE) ? {7'b0, m_drv} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_oe();
    return (mode == M_SC) ? m_dir : ext_oe;
  endfunction

  function automatic logic [7:0] exp_out();
    return (mode == M_SC) ? m_data : ext_out;
  endfunction

  function automatic logic [7:0] exp_pu();
    return (mode == M_SC && m_pull) ? ~m_dir : 8'h00;
  endfunction

  function automatic logic [7:0] exp_rdrv();
    return m_drv ? exp_oe() : 8'h00;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_data = '0; m_dir = '0; m_pull = 1'b0; m_drv = 1'b0; m_lock = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    if (a == 3'd0 && mode == M_SC) m_data = d;
    if (a == 3'd1 && mode == M_SC) m_dir = d;
    if (a == 3'd2) m_pull = d[0];
    if (a == 3'd3 && mode != M_PE && !m_lock) begin m_drv = d[0]; m_lock = 1'b1; end
  endtask

  task automatic rd_check(input logic [2:0] a, input string req);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 check(req, $sformatf("read ofs %0d", a), rdata, exp_rd(a));
    rd_en = 1'b0;
  endtask

  task automatic pad_check(input string req);
    @(negedge clk);
    #1;
    check(req, "pad_oe", pad_oe, exp_oe());
    check(req, "pad_out", pad_out, exp_out());
    check(req, "pad_pu", pad_pu, exp_pu());
    check(req, "pad_rdrv", pad_rdrv, exp_rdrv());
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk); pin_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: reset state, all pins inputs, read shows pins
    rd_check(3'd1, "R2");
    rd_check(3'd2, "R2");
    rd_check(3'd3, "R2");
    pad_check("R2");
    rd_check(3'd0, "R4");

    // R1: direction and latch drive the pads
    do_write(3'd1, 8'hF0);
    do_write(3'd0, 8'h3C);
    pad_check("R1");

    // R4: mixed read-back and two-edge synchronizer latency
    set_pins(8'h00);
    rd_check(3'd0, "R4");
    @(negedge clk); pin_in = 8'hFF;
    @(negedge clk); addr = 3'd0; rd_en = 1'b1;
    #1 check("R4", "one edge after pin change", rdata, 8'h30);
    @(negedge clk);
    #1 check("R4", "two edges after pin change", rdata, 8'h3F);
    rd_en = 1'b0;

    // R5: pull-ups on input pins only
    do_write(3'd2, 8'hFF);
    pad_check("R5");
    rd_check(3'd2, "R10");

    // R6, R3: expanded mode hides registers and hands pads over
    ext_out = 8'h96; ext_oe = 8'h0F;
    set_mode(M_XN);
    pad_check("R6");
    rd_check(3'd0, "R3");
    rd_check(3'd1, "R3");
    do_write(3'd0, 8'hFF);
    do_write(3'd1, 8'h00);
    set_mode(M_XW);
    pad_check("R3");
    set_mode(M_SC);
    rd_check(3'd1, "R3");
    pad_check("R3");

    // R7, R8: drive bit write once
    do_write(3'd3, 8'h01);
    pad_check("R7");
    do_write(3'd3, 8'h00);
    rd_check(3'd3, "R8");
    pad_check("R8");

    // R9: peripheral-mode write neither sets nor locks
    do_reset();
    set_mode(M_PE);
    do_write(3'd3, 8'h01);
    rd_check(3'd3, "R9");
    set_mode(M_SC);
    rd_check(3'd3, "R9");
    do_write(3'd3, 8'h01);
    do_write(3'd3, 8'h00);
    rd_check(3'd3, "R9");

    // R10: unused offsets and idle strobe
    for (int a = 4; a < 8; a++) rd_check(3'(a), "R10");
    @(negedge clk); addr = 3'd2; rd_en = 1'b0;
    #1 check("R10", "idle read", rdata, 8'h00);

    // Random mix across all requirements
    for (int it = 0; it < 400; it++) begin
      int unsigned op = $urandom % 10;
      if (op < 5) do_write(3'($urandom % 8), 8'($urandom));
      else if (op < 7) set_pins(8'($urandom));
      else if (op == 7) set_mode(($urandom % 5 < 3) ? M_SC : 2'($urandom));
      else if (op == 8) begin
        @(negedge clk); ext_out = 8'($urandom); ext_oe = 8'($urandom);
      end else if ($urandom % 5 == 0) do_reset();
      repeat (2) @(negedge clk);
      pad_check("R1 R5 R6 R7");
      rd_check(3'($urandom % 8), "R3 R4 R8 R9 R10");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule